// File: doc/BRIEF.md
# Type 1 Configuration Address Translator

This block watches the primary side of a PCI-to-PCI bridge during each address phase. When a Type 1 configuration read or write is aimed at the bus that sits directly behind the bridge, the block claims the cycle. It then produces the Type 0 address that the bridge drives on its secondary bus.

The secondary bus is identified by the bridge's secondary bus number register. The translated address carries a one-hot device-select pattern in its upper half, and that pattern can drive the target device's IDSEL line. The function and register fields pass through unchanged. The device field is cleared when the secondary bus runs conventional PCI and is kept when it runs PCI-X.

Each access is a single DWord with one data phase. The block only handles the address. Data phases, upstream traffic and forwarding of Type 1 cycles to buses further down are handled elsewhere.

Top module: `cfg_t1_translator`

## Requirements
- R1: A claim follows an address phase only when all three of these hold on that phase: the active-low command nibble is configuration read (4'b1010) or configuration write (4'b1011), primary AD[1:0] is 2'b01, and primary AD[23:16] equals `secBusNum`.
- R2: Every other command value (for example 4'b0110 or 4'b0011) never produces a claim, and the secondary address keeps its value.
- R3: On every translated address, AD[1:0] is 2'b00.
- R4: Device numbers 0 to 15 (primary AD[15:11]) set exactly bit 16+n of the secondary address, with AD[31:16] otherwise zero. Device numbers 16 to 31 give AD[31:16] all zero.
- R5: With `pcixMode` low, secondary AD[15:11] is 5'b00000. With `pcixMode` high, it equals primary AD[15:11].
- R6: The function field AD[10:8] and the register field AD[7:2] are copied unchanged.
- R7: `claim` and `secValid` rise together one clock after the address-phase strobe and stay high for exactly one cycle.
- R8: A cycle whose bus number differs from `secBusNum` gives no claim, and `secAd` keeps its previous value.
- R9: Reset drives `claim`, `secValid` and `secAd` to zero.
- R10: A cycle with primary AD[1:0] other than 2'b01 (a Type 0 or reserved encoding) gives no claim, and `secAd` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| priAd | input | 32 | Primary address/data bus |
| priCbeN | input | 4 | Primary command nibble, active low |
| addrPhase | input | 1 | Strobe marking the primary address phase |
| secBusNum | input | 8 | Secondary bus number register value |
| pcixMode | input | 1 | High when the secondary bus runs PCI-X |
| claim | output | 1 | One-cycle claim of the configuration cycle |
| secAd | output | 32 | Translated Type 0 secondary address |
| secValid | output | 1 | One-cycle flag marking a new `secAd` |

## Verification
The properties assume that the address-phase strobe never stays high for two clocks in a row, because on a real bus every address phase is followed by at least one data phase. The one-cycle valid check depends on this. The stimulus leaves two idle clocks after every strobe. The properties also assume that `secBusNum` and `pcixMode` hold steady around each strobe. The stimulus changes them only between transactions.

// File: rtl/t1x_pkg.sv
package t1x_pkg;
  // Command nibble encodings (active-low bus values)
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
  // Address-phase type code for a Type 1 configuration cycle
  localparam logic [1:0] TYPE1_CODE = 2'b01;
  localparam logic [1:0] TYPE0_CODE = 2'b00;

  // Field positions inside a configuration address
  localparam int BUS_LSB  = 16;
  localparam int DEV_LSB  = 11;
  localparam int DEV_W    = 5;
  localparam int FUNC_LSB = 8;
  localparam int FUNC_W   = 3;
  localparam int REG_LSB  = 2;
  localparam int REG_W    = 6;
  localparam int SEL_LSB  = 16;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;
  } ctlStrobe_t;
endpackage

// File: rtl/t1x_ctrl.sv
module t1x_ctrl
  import t1x_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrPhase,
  input  logic [3:0]       cmdN,
  input  logic [1:0]       typeBits,
  input  logic [BUS_W-1:0] busField,
  input  logic [BUS_W-1:0] secBusNum,
  output ctlStrobe_t       strobe,
  output logic             claim,
  output logic             secValid
);
  logic isCfgCmd;
  logic isType1;
  logic busHit;

  always_comb begin
    isCfgCmd    = (cmdN == CMD_CFG_RD) || (cmdN == CMD_CFG_WR);
    isType1     = (typeBits == TYPE1_CODE);
    busHit      = (busField == secBusNum);
    strobe.load = addrPhase && isCfgCmd && isType1 && busHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      claim    <= 1'b0;
      secValid <= 1'b0;
    end else begin
      claim    <= strobe.load;
      secValid <= strobe.load;
    end
  end
endmodule

// File: rtl/t1x_dpath.sv
module t1x_dpath
  import t1x_pkg::*;
#(
  parameter int AD_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      strobe,
  input  logic [AD_W-1:0] priAd,
  input  logic            pcixMode,
  output logic [AD_W-1:0] secAd
);
  localparam int SEL_W = AD_W - SEL_LSB;

  logic [DEV_W-1:0]  devNum;
  logic [SEL_W-1:0]  idselVec;
  logic [AD_W-1:0]   nextAd;
  logic              unusedHiBits;

  assign devNum       = priAd[DEV_LSB +: DEV_W];
  assign unusedHiBits = ^priAd[AD_W-1:BUS_LSB];

  // One select line per decodable device; numbers past SEL_W-1 select none
  for (genvar i = 0; i < SEL_W; i++) begin : g_idsel
    assign idselVec[i] = (devNum == DEV_W'(i));
  end

  always_comb begin
    nextAd                          = '0;
    nextAd[REG_LSB  +: REG_W]       = priAd[REG_LSB +: REG_W];
    nextAd[FUNC_LSB +: FUNC_W]      = priAd[FUNC_LSB +: FUNC_W];
    nextAd[DEV_LSB  +: DEV_W]       = pcixMode ? devNum : '0;
    nextAd[AD_W-1:SEL_LSB]          = idselVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            secAd <= '0;
    else if (strobe.load) secAd <= nextAd;
  end
endmodule

// File: rtl/cfg_t1_translator.sv
module cfg_t1_translator
  import t1x_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AD_W-1:0]  priAd,
  input  logic [3:0]       priCbeN,
  input  logic             addrPhase,
  input  logic [BUS_W-1:0] secBusNum,
  input  logic             pcixMode,
  output logic             claim,
  output logic [AD_W-1:0]  secAd,
  output logic             secValid
);
  ctlStrobe_t strobe;

  t1x_ctrl #(.BUS_W(BUS_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .addrPhase (addrPhase),
    .cmdN      (priCbeN),
    .typeBits  (priAd[1:0]),
    .busField  (priAd[BUS_LSB +: BUS_W]),
    .secBusNum (secBusNum),
    .strobe    (strobe),
    .claim     (claim),
    .secValid  (secValid)
  );

  t1x_dpath #(.AD_W(AD_W)) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .priAd    (priAd),
    .pcixMode (pcixMode),
    .secAd    (secAd)
  );
endmodule

// File: rtl/t1x_checker.sv
module t1x_checker (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] priAd,
  input logic [3:0]  priCbeN,
  input logic        addrPhase,
  input logic [7:0]  secBusNum,
  input logic        pcixMode,
  input logic        claim,
  input logic [31:0] secAd,
  input logic        secValid
);
  // Input assumption: address phases are never back to back
  p_strobe_gap_in: assert property (@(posedge clk) disable iff (!rstN)
    addrPhase |=> !addrPhase);

  // R1 / R2 / R10: claim only after a matching configuration Type 1 phase
  p_claim_cond_r1: assert property (@(posedge clk) disable iff (!rstN)
    claim |-> ($past(addrPhase) && $past(priAd[1:0]) == 2'b01 &&
               $past(priAd[23:16]) == $past(secBusNum)));
  p_claim_cmd_r2: assert property (@(posedge clk) disable iff (!rstN)
    claim |-> ($past(priCbeN) == 4'b1010 || $past(priCbeN) == 4'b1011));

  p_low_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    secValid |-> secAd[1:0] == 2'b00);

  p_idsel_r4: assert property (@(posedge clk) disable iff (!rstN)
    secValid |-> (($past(priAd[15]) && secAd[31:16] == 16'h0) ||
                  (!$past(priAd[15]) && secAd[31:16] == (16'h1 << $past(priAd[14:11])))));
  p_idsel_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(secAd[31:16]));

  p_devfield_r5: assert property (@(posedge clk) disable iff (!rstN)
    secValid |-> secAd[15:11] == ($past(pcixMode) ? $past(priAd[15:11]) : 5'd0));

  p_fields_r6: assert property (@(posedge clk) disable iff (!rstN)
    secValid |-> secAd[10:2] == $past(priAd[10:2]));

  p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rstN)
    secValid |=> !secValid);
  p_claim_pair_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(claim) |-> $past(addrPhase));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !secValid |-> $stable(secAd));
endmodule

bind cfg_t1_translator t1x_checker i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .priAd     (priAd),
  .priCbeN   (priCbeN),
  .addrPhase (addrPhase),
  .secBusNum (secBusNum),
  .pcixMode  (pcixMode),
  .claim     (claim),
  .secAd     (secAd),
  .secValid  (secValid)
);

// File: tb/test_cfg_t1_translator.sv
module test_cfg_t1_translator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] priAd = '0;
  logic [3:0]  priCbeN = 4'hF;
  logic        addrPhase = 1'b0;
  logic [7:0]  secBusNum = 8'h3C;
  logic        pcixMode = 1'b0;
  logic        claim;
  logic [31:0] secAd;
  logic        secValid;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [31:0] lastAd = '0;

  typedef struct {
    logic        expClaim;
    logic [31:0] expAd;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;

  cfg_t1_translator i_cfg_t1_translator (
    .clk(clk), .rstN(rstN), .priAd(priAd), .priCbeN(priCbeN),
    .addrPhase(addrPhase), .secBusNum(secBusNum), .pcixMode(pcixMode),
    .claim(claim), .secAd(secAd), .secValid(secValid));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] build(input logic [31:0] a, input logic px);
    logic [31:0] r;
    r = '0;
    r[7:2]  = a[7:2];
    r[10:8] = a[10:8];
    r[15:11] = px ? a[15:11] : 5'd0;
    if (a[15:11] < 5'd16) r[16 + a[15:11]] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] mkAd(input logic [7:0] bus, input logic [4:0] dev,
                                       input logic [2:0] fn, input logic [5:0] rg,
                                       input logic [1:0] typ);
    return {8'hA5, bus, dev, fn, rg, typ};
  endfunction

  // Driver: one address phase, then two idle clocks
  task automatic send(input logic [3:0] cmd, input logic [31:0] ad,
                      input logic px, input string tag);
    item_t it;
    logic hit;
    @(negedge clk);
    priCbeN = cmd; priAd = ad; pcixMode = px; addrPhase = 1'b1;
    hit = (cmd == 4'b1010 || cmd == 4'b1011) && ad[1:0] == 2'b01 && ad[23:16] == secBusNum;
    if (hit) lastAd = build(ad, px);
    it.expClaim = hit; it.expAd = lastAd; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    addrPhase = 1'b0; priAd = 32'hFFFF_FFFF; priCbeN = 4'hF;
    @(negedge clk);
  endtask

  // Monitor: compare outputs one clock after each strobe, then the cycle after
  initial begin
    forever begin
      item_t it;
      wait (sbq.size() > 0);
      @(posedge clk); #2;
      it = sbq.pop_front();
      check({it.tag, " claim"}, {31'd0, claim}, {31'd0, it.expClaim});
      check({it.tag, " valid"}, {31'd0, secValid}, {31'd0, it.expClaim});
      check({it.tag, " secAd"}, secAd, it.expAd);
      @(posedge clk); #2;
      check("R7 valid one cycle", {31'd0, secValid}, 32'd0);
      check("R7 claim one cycle", {31'd0, claim}, 32'd0);
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset claim", {31'd0, claim}, 32'd0);
    check("R9 reset valid", {31'd0, secValid}, 32'd0);
    check("R9 reset secAd", secAd, 32'd0);
    rstN = 1'b1;

    send(4'b1010, mkAd(8'h3C, 5'd0, 3'd3, 6'd5, 2'b01), 1'b0, "R1 R4 R5 cfg read dev0 conv");
    send(4'b1011, mkAd(8'h3C, 5'd15, 3'd7, 6'h3F, 2'b01), 1'b1, "R1 R4 R5 cfg write dev15 pcix");
    send(4'b1010, mkAd(8'h3C, 5'd20, 3'd2, 6'h2A, 2'b01), 1'b0, "R4 dev20 no idsel");
    send(4'b1011, mkAd(8'h3C, 5'd31, 3'd1, 6'h15, 2'b01), 1'b1, "R4 R5 dev31 pcix");
    send(4'b1010, mkAd(8'h3D, 5'd4, 3'd0, 6'd1, 2'b01), 1'b0, "R8 bus mismatch");
    send(4'b0110, mkAd(8'h3C, 5'd4, 3'd0, 6'd1, 2'b01), 1'b0, "R2 memory read cmd");
    send(4'b0011, mkAd(8'h3C, 5'd4, 3'd0, 6'd1, 2'b01), 1'b1, "R2 io write cmd");
    send(4'b1010, mkAd(8'h3C, 5'd4, 3'd0, 6'd1, 2'b00), 1'b0, "R10 type0 encoding");
    send(4'b1011, mkAd(8'h3C, 5'd4, 3'd0, 6'd1, 2'b11), 1'b0, "R10 reserved encoding");
    send(4'b1010, mkAd(8'h3C, 5'd9, 3'd5, 6'h11, 2'b01), 1'b1, "R3 R6 R7 dev9");

    secBusNum = 8'h01;
    send(4'b1010, mkAd(8'h3C, 5'd2, 3'd0, 6'd0, 2'b01), 1'b0, "R8 old bus number");
    for (int d = 0; d < 32; d++) begin
      send(4'b1011, mkAd(8'h01, 5'(d), 3'(d), 6'(d * 3), 2'b01), 1'b0, "R4 R5 R6 sweep conv");
      send(4'b1010, mkAd(8'h01, 5'(d), 3'(7 - (d % 8)), 6'(63 - d), 2'b01), 1'b1, "R4 R5 R6 sweep pcix");
    end

    send(4'b1010, mkAd(8'h01, 5'd6, 3'd4, 6'd8, 2'b01), 1'b1, "R1 final load");
    wait (sbq.size() == 0);
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R9 reset clears secAd", secAd, 32'd0);
    check("R9 reset clears claim", {31'd0, claim}, 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule